// File: doc/BRIEF.md
# Non-Maskable Interrupt Property Register Bank

This block keeps one "non-maskable" flag for every shared peripheral interrupt that a distributor handles. Software reaches the flags through a window of 32-bit words on a simple single-cycle register bus. The word at index n covers interrupt IDs 32*n to 32*n+31, and the flag for ID m sits in bit m MOD 32.

Each flag is filtered before it can be read, written or driven out. The filter depends on:
- whether the controller supports non-maskable interrupts at all;
- how many register words are implemented;
- the interrupt's group and group-modifier inputs;
- the global security-disable control;
- the security attribute of the access.

The prioritisation logic receives the stored flags ANDed with a per-interrupt eligibility mask. That mask is recomputed combinationally, so a change to the group configuration hides or reveals a flag at once, without touching the stored value.

Top module: `nmi_prop_bank`

## Requirements
- R1: Word n of the bank sits at byte address BASE + 4*n (BASE defaults to 0xF80; n is 0 to NUM_REGS-1). The flag for interrupt ID m is bit (m MOD 32) of word (m DIV 32). Read data appears on `bus_rdata` in the cycle after the read is accepted, and is zero in every other cycle.
- R2: After reset every stored flag is 0, `bus_rdata` is 0 and `nmi_out` is all zero.
- R3: An access whose address has bits [1:0] not equal to 0, or which falls outside the window, reads zero and changes no flag.
- R4: Bits for IDs 0 to 31 (all of word 0) read as zero, ignore writes and are never driven on `nmi_out`.
- R5: Words with an index greater than `impl_lines` read as zero and ignore writes. Raising `impl_lines` later reveals no data written while the word was absent.
- R6: When `nmi_en` is 0, the whole bank reads as zero, ignores writes and drives `nmi_out` to zero. Stored flags are kept and reappear when `nmi_en` returns to 1.
- R7: An interrupt is Group 0 when `irq_group[m]`=0 and either `sec_disable`=1 or `irq_grpmod[m]`=0. Its flag reads 0 and is not set by a write, even if the interrupt is moved to another group afterwards.
- R8: With `sec_disable`=0 and `bus_ns`=1, the flags of interrupts with `irq_group[m]`=0 read as 0 and ignore writes. A Secure Group 1 flag (`irq_group`=0, `irq_grpmod`=1) is readable and writable by a secure access (`bus_ns`=0).
- R9: `nmi_out[m]` equals the stored flag ANDed with the current eligibility of ID m. A configuration change that makes an interrupt ineligible hides its flag in the same cycle. Reversing the change shows the kept flag again.
- R10: A write takes effect on `nmi_out` in the cycle after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_en | input | 1 | Controller supports non-maskable interrupts |
| sec_disable | input | 1 | Single security state; group modifier ignored |
| impl_lines | input | LINES_W | Index of the last implemented word |
| irq_group | input | NUM_IRQ | Per-ID group bit (1 = non-secure Group 1) |
| irq_grpmod | input | NUM_IRQ | Per-ID group modifier |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_ns | input | 1 | Access is non-secure |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| nmi_out | output | NUM_IRQ | Effective non-maskable flags per interrupt ID |

## Verification
The bank is written with mixed and all-ones patterns under four group arrangements per word: non-secure Group 1, Group 0, Secure Group 1, and a Secure Group 1 range that becomes Group 0 once security is disabled. Secure and non-secure reads of the same word then show which bits the access filter opened for each side. Writes made while a bit was ineligible are read back after the bit becomes eligible, which separates "read masked" from "write dropped". Misaligned, below-window and not-implemented addresses are paired with a read of a valid word to prove nothing leaked into storage.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic [1:0] {
    CLS_G0   = 2'd0,
    CLS_SG1  = 2'd1,
    CLS_NSG1 = 2'd2
  } irq_class_e;

  function automatic irq_class_e classify(input logic grp, input logic mod, input logic sd);
    if (grp) return CLS_NSG1;
    if (!sd && mod) return CLS_SG1;
    return CLS_G0;
  endfunction
endpackage

// File: rtl/nmi_addr_decode.sv
module nmi_addr_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  parameter logic [ADDR_W-1:0] BASE = 12'hF80
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NUM_REGS * 4);
  logic [ADDR_W:0] off;

  always_comb begin
    off = {1'b0, addr} - {1'b0, BASE};
    hit = (addr >= BASE) && (off < SPAN) && (addr[1:0] == 2'b00);
    idx = off[IDX_W+1:2];
  end
endmodule

// File: rtl/nmi_elig_mask.sv
module nmi_elig_mask
  import nmi_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 1024,
  parameter int LINES_W = 5
) (
  input  logic               nmi_en,
  input  logic               sec_disable,
  input  logic               bus_ns,
  input  logic [LINES_W-1:0] impl_lines,
  input  logic [NUM_IRQ-1:0] irq_group,
  input  logic [NUM_IRQ-1:0] irq_grpmod,
  output logic [NUM_IRQ-1:0] elig,
  output logic [NUM_IRQ-1:0] acc
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (i < DATA_W) begin : g_private
      assign elig[i] = 1'b0;
      assign acc[i]  = 1'b0;
    end else begin : g_shared
      irq_class_e cls;
      assign cls     = classify(irq_group[i], irq_grpmod[i], sec_disable);
      assign elig[i] = nmi_en && (cls != CLS_G0) &&
                       (32'(impl_lines) >= 32'(i / DATA_W));
      assign acc[i]  = elig[i] && (!bus_ns || sec_disable || cls == CLS_NSG1);
    end
  end
endmodule

// File: rtl/nmi_flag_store.sv
module nmi_flag_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  localparam int NUM_IRQ = NUM_REGS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  wmask,
  output logic [NUM_IRQ-1:0] q
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_REGS; w++) mem[w] <= '0;
    end else if (we) begin
      mem[widx] <= (mem[widx] & ~wmask) | (wdata & wmask);
    end
  end

  for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
    assign q[w*DATA_W +: DATA_W] = mem[w];
  end
endmodule

// File: rtl/nmi_prop_bank.sv
module nmi_prop_bank #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int LINES_W  = 5,
  parameter logic [ADDR_W-1:0] BASE = 12'hF80,
  localparam int NUM_IRQ = NUM_REGS * DATA_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_en,
  input  logic               sec_disable,
  input  logic [LINES_W-1:0] impl_lines,
  input  logic [NUM_IRQ-1:0] irq_group,
  input  logic [NUM_IRQ-1:0] irq_grpmod,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_ns,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_IRQ-1:0] nmi_out
);
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [NUM_IRQ-1:0] elig, acc, stored;
  logic [DATA_W-1:0] acc_word, data_word;
  logic              wr_go, rd_go;

  nmi_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  nmi_elig_mask #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .LINES_W(LINES_W)) u_mask (
    .nmi_en(nmi_en), .sec_disable(sec_disable), .bus_ns(bus_ns),
    .impl_lines(impl_lines), .irq_group(irq_group), .irq_grpmod(irq_grpmod),
    .elig(elig), .acc(acc)
  );

  assign wr_go     = bus_valid && bus_write && hit;
  assign rd_go     = bus_valid && !bus_write && hit;
  assign acc_word  = acc[idx*DATA_W +: DATA_W];
  assign data_word = stored[idx*DATA_W +: DATA_W];

  nmi_flag_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(wr_go), .widx(idx),
    .wdata(bus_wdata), .wmask(acc_word), .q(stored)
  );

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= data_word & acc_word;
    else            bus_rdata <= '0;
  end

  assign nmi_out = stored & elig;
endmodule

// File: rtl/nmi_prop_bank_chk.sv
module nmi_prop_bank_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_IRQ = 1024
) (
  input logic               clk,
  input logic               rst,
  input logic               nmi_en,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_IRQ-1:0] nmi_out
);
  a_r2_reset_clears_rdata: assert property (@(posedge clk) rst |=> bus_rdata == '0);

  a_r1_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> bus_rdata == '0);

  a_r3_misaligned_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  a_r4_private_ids_hidden: assert property (@(posedge clk) disable iff (rst)
    nmi_out[DATA_W-1:0] == '0);

  a_r6_disabled_output_zero: assert property (@(posedge clk) disable iff (rst)
    !nmi_en |-> nmi_out == '0);

  a_r6_disabled_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !nmi_en) |=> bus_rdata == '0);
endmodule

bind nmi_prop_bank nmi_prop_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .nmi_en(nmi_en), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .nmi_out(nmi_out)
);

// File: tb/tb_nmi_prop_bank.sv
module tb_nmi_prop_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int NIRQ = NREG * 32;
  localparam int BASE = 'hF80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_en = 1'b0, sec_disable = 1'b0;
  logic [4:0] impl_lines = 5'd3;
  logic [NIRQ-1:0] irq_group = '1, irq_grpmod = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_ns = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NIRQ-1:0] nmi_out;

  int checks = 0, errors = 0;
  bit mon_en = 1'b0, done = 1'b0;
  bit mdl [NIRQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_prop_bank dut (
    .clk(clk), .rst(rst), .nmi_en(nmi_en), .sec_disable(sec_disable), .impl_lines(impl_lines),
    .irq_group(irq_group), .irq_grpmod(irq_grpmod), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_ns(bus_ns), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_out(nmi_out)
  );

  function automatic bit eligible(int m);
    bit g0 = !irq_group[m] && (sec_disable || !irq_grpmod[m]);
    return nmi_en && m >= 32 && (m / 32) <= int'(impl_lines) && !g0;
  endfunction

  function automatic bit allowed(int m, bit ns);
    return eligible(m) && (!ns || sec_disable || irq_group[m]);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (mon_en && !done) begin
      logic [NIRQ-1:0] expv;
      int bad;
      bad = -1;
      for (int m = 0; m < NIRQ; m++) begin
        expv[m] = mdl[m] && eligible(m);
        if (bad < 0 && expv[m] !== nmi_out[m]) bad = m;
      end
      check(bad < 0, "R9 nmi_out model", (bad < 0) ? 32'd0 : 32'(nmi_out[bad]),
            (bad < 0) ? 32'd0 : 32'(expv[bad]));
    end
  end

  task automatic do_write(int addr, bit ns, logic [31:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_ns = ns;
    bus_addr = addr[11:0]; bus_wdata = wd;
    @(posedge clk);
    if (addr >= BASE && addr < BASE + 4*NREG && addr % 4 == 0)
      for (int b = 0; b < 32; b++) begin
        int m = ((addr - BASE) / 4) * 32 + b;
        if (allowed(m, ns)) mdl[m] = wd[b];
      end
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(int addr, bit ns, logic [31:0] exp, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_ns = ns; bus_addr = addr[11:0];
    @(posedge clk);
    #1 bus_valid = 1'b0;
    @(negedge clk);
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NIRQ; m++) mdl[m] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_rdata === 32'd0, "R2 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0; nmi_en = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    check(nmi_out === '0, "R2 nmi_out after reset", 32'(nmi_out[63:32]), 32'd0);
    do_read(BASE + 4, 1'b0, 32'd0, "R2 word1 after reset");

    // R1 basic store and readback
    do_write(BASE + 4, 1'b0, 32'hA5A5_0F0F);
    do_read(BASE + 4, 1'b0, 32'hA5A5_0F0F, "R1 word1 readback");
    check(nmi_out[32] === 1'b1 && nmi_out[40] === 1'b1 && nmi_out[36] === 1'b0,
          "R1 ID-to-bit mapping", 32'(nmi_out[47:32]), 32'h0F0F);

    // R4 word 0
    do_write(BASE, 1'b0, 32'hFFFF_FFFF);
    do_read(BASE, 1'b0, 32'd0, "R4 word0 read zero");

    // R5 unimplemented words
    do_write(BASE + 16, 1'b0, 32'hFFFF_FFFF);
    do_read(BASE + 16, 1'b0, 32'd0, "R5 word4 absent");
    do_read(BASE + 124, 1'b0, 32'd0, "R5 word31 absent");
    @(negedge clk) impl_lines = 5'd4;
    do_read(BASE + 16, 1'b0, 32'd0, "R5 word4 kept no stale write");
    do_write(BASE + 16, 1'b0, 32'h0000_0001);
    do_read(BASE + 16, 1'b0, 32'h0000_0001, "R5 word4 now present");

    // R3 misaligned and out of window
    do_write(BASE + 5, 1'b0, 32'h0);
    do_read(BASE + 4, 1'b0, 32'hA5A5_0F0F, "R3 misaligned write ignored");
    do_read(BASE + 6, 1'b0, 32'd0, "R3 misaligned read zero");
    do_write(BASE - 4, 1'b0, 32'hFFFF_FFFF);
    do_read(BASE - 4, 1'b0, 32'd0, "R3 below window read zero");

    // R10 write visible next cycle
    do_write(BASE + 4, 1'b0, 32'h0000_0002);
    check(nmi_out[33] === 1'b1 && nmi_out[32] === 1'b0, "R10 write to output latency",
          32'(nmi_out[35:32]), 32'h2);
    do_write(BASE + 4, 1'b0, 32'hA5A5_0F0F);

    // R7 Group 0 bits
    @(negedge clk) irq_group[79:64] = '0; irq_grpmod[79:64] = '0;
    do_write(BASE + 8, 1'b0, 32'hFFFF_FFFF);
    do_read(BASE + 8, 1'b0, 32'hFFFF_0000, "R7 group0 bits read zero");
    @(negedge clk) irq_group[79:64] = '1;
    do_read(BASE + 8, 1'b0, 32'hFFFF_0000, "R7 group0 write not stored");

    // R8 security filtering
    @(negedge clk) irq_group[103:96] = '0; irq_grpmod[103:96] = '1;
    do_write(BASE + 12, 1'b1, 32'hFFFF_FFFF);
    do_read(BASE + 12, 1'b0, 32'hFFFF_FF00, "R8 ns write skips secure bits");
    do_write(BASE + 12, 1'b0, 32'hFFFF_FFFF);
    do_read(BASE + 12, 1'b0, 32'hFFFF_FFFF, "R8 secure access to secure grp1");
    do_read(BASE + 12, 1'b1, 32'hFFFF_FF00, "R8 ns read hides secure bits");

    // R9 reconfiguration hides and restores
    @(negedge clk) sec_disable = 1'b1;
    #2 check(nmi_out[96] === 1'b0 && nmi_out[104] === 1'b1, "R9 hidden on sec_disable",
             32'(nmi_out[104:96]), 32'h100);
    do_read(BASE + 12, 1'b0, 32'hFFFF_FF00, "R9 read while hidden");
    @(negedge clk) sec_disable = 1'b0;
    #2 check(nmi_out[96] === 1'b1, "R9 flag restored", 32'(nmi_out[96]), 32'd1);
    do_read(BASE + 12, 1'b0, 32'hFFFF_FFFF, "R9 read after restore");

    // R6 global disable
    @(negedge clk) nmi_en = 1'b0;
    #2 check(nmi_out === '0, "R6 output zero when off", 32'(nmi_out[63:32]), 32'd0);
    do_read(BASE + 4, 1'b0, 32'd0, "R6 read zero when off");
    do_write(BASE + 4, 1'b0, 32'd0);
    @(negedge clk) nmi_en = 1'b1;
    do_read(BASE + 4, 1'b0, 32'hA5A5_0F0F, "R6 write ignored when off");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule